// File: doc/BRIEF.md
# DDR2 Command Decode and Bank Tracker

This block is a synchronous model of the command front end inside a DDR2-style memory device. On every rising clock edge it samples the clock enable, chip select, the three active-low command strobes, the bank address and the address bus. From these it decodes one command. It keeps an open/closed flag and the open row for every bank, and it tracks the device's low-power state.

The decoded command comes out one cycle after the edge that sampled it. READ and WRITE report the bank and the column address, with address bit 10 removed, plus the auto-precharge flag. A mode-register-set cycle reports which register the bank address selects and the opcode on the address bus. Illegal bank accesses raise a one-cycle error pulse.

When CKE is sampled low, the device enters one of three states:
- self refresh, if a REFRESH command arrives on that edge;
- active power-down, if any row is open;
- precharge power-down, otherwise.

Commands are ignored until the device exits. Exit from self refresh is seen as soon as CKE rises, without waiting for a clock edge. A configuration for the smaller densities ignores the top bank address bit and tracks half the banks.

Top module: `ddr2_cmd_front`

## Requirements
- R1: After reset all banks are closed, every row output is zero, `cmd_o` is NOP (0), `err_o` is 0 and `pwr_o` is RUN (0).
- R2: When `cs_n` is sampled high, the cycle is a NOP: `cmd_o` shows 0 and no bank state changes.
- R3: With `cs_n` low, {ras_n,cas_n,we_n} decodes as follows, shown on `cmd_o` one cycle after the sampling edge:
  - 011 = ACTIVE (1)
  - 101 = READ (2)
  - 100 = WRITE (3)
  - 010 = PRECHARGE (4)
  - 000 = mode set (5)
  - 001 = REFRESH (6)
  - any other code = NOP (0)
- R4: ACTIVE to a closed bank opens it and stores `addr` as its row. READ and WRITE set `bank_o`, set `col_o` to `addr` with bit 10 removed (bits above 10 shift down by one), and set `a10_o` to `addr[10]`.
- R5: A READ or WRITE to an open bank with `addr[10]` high closes that bank in the same cycle that it is reported.
- R6: PRECHARGE with `addr[10]` low closes only the addressed bank. With `addr[10]` high it closes all banks.
- R7: A mode set puts `ba` on `mode_sel_o` and `addr` on `mode_op_o`. Both outputs are zero for every other command.
- R8: `err_o` pulses for one cycle in these cases:
  - READ or WRITE to a closed bank;
  - single-bank PRECHARGE to a closed bank;
  - ACTIVE to an open bank.
  An ACTIVE to an open bank leaves the stored row unchanged.
- R9: CKE sampled low while RUN changes `pwr_o` on the next cycle:
  - to self refresh (3), if the same edge carries REFRESH;
  - otherwise to active power-down (2), if any bank was open;
  - otherwise to precharge power-down (1).
- R10: CKE sampled high in either power-down state returns `pwr_o` to RUN on the next cycle. Commands are ignored, with `cmd_o` = 0 and banks unchanged, on these edges:
  - the entry edge;
  - every edge spent in a low-power state;
  - the exit edge.
- R11: In self refresh, `pwr_o` shows RUN as soon as `cke` is high, before any clock edge.
- R12: With SMALL=1 the top bank address bit is ignored for bank tracking. Only the lower half of the banks can open, and the upper `bank_open_o` bits stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock, rising edge samples all inputs |
| rst_n | input | 1 | Active-low asynchronous reset |
| cke | input | 1 | Clock enable |
| cs_n | input | 1 | Active-low chip select |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| ba | input | BA_W | Bank address |
| addr | input | ADDR_W | Row, column/flag or opcode |
| cmd_o | output | 3 | Decoded command code |
| bank_o | output | BA_W | Bank the command targeted |
| col_o | output | ADDR_W-1 | Column address for READ/WRITE |
| a10_o | output | 1 | Sampled address bit 10 |
| mode_sel_o | output | BA_W | Register selected by a mode set |
| mode_op_o | output | ADDR_W | Opcode of a mode set |
| err_o | output | 1 | One-cycle illegal bank access flag |
| bank_open_o | output | 2**BA_W | Open flag per bank |
| row_o | output | 2**BA_W*ADDR_W | Open row per bank, bank 0 lowest |
| pwr_o | output | 2 | 0 RUN, 1 precharge power-down, 2 active power-down, 3 self refresh |

## Verification
One case has a command and a CKE fall on the same edge. An ACTIVE arrives on the edge where CKE is first sampled low with all banks idle. The device must enter precharge power-down, because the choice uses the bank state before that edge, and the ACTIVE must leave the bank closed. A second case has an access and a bank closing at once. An auto-precharge READ/WRITE is judged by checking that the command is reported and the bank flag drops in the same cycle. A second ACTIVE to an already open bank is judged by checking that the error pulse and the preserved row appear together.

// File: rtl/ddr2_fe_pkg.sv
package ddr2_fe_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4,
        CMD_MRS = 3'd5,
        CMD_REF = 3'd6
    } cmd_e;

    typedef enum logic [1:0] {
        PW_RUN  = 2'd0,
        PW_PPD  = 2'd1,
        PW_APD  = 2'd2,
        PW_SREF = 2'd3
    } pwr_e;

    // Map the sampled pins to a command, masked by chip select.
    function automatic cmd_e decode_pins(input logic cs_n, input logic ras_n,
                                         input logic cas_n, input logic we_n);
        cmd_e c;
        c = CMD_NOP;
        if (!cs_n) begin
            case ({ras_n, cas_n, we_n})
                3'b011:  c = CMD_ACT;
                3'b101:  c = CMD_RD;
                3'b100:  c = CMD_WR;
                3'b010:  c = CMD_PRE;
                3'b000:  c = CMD_MRS;
                3'b001:  c = CMD_REF;
                default: c = CMD_NOP;
            endcase
        end
        return c;
    endfunction

endpackage

// File: rtl/ddr2_fe_pwr.sv
module ddr2_fe_pwr
    import ddr2_fe_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cke,
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    input  logic any_open,
    output logic accept,
    output logic [1:0] pwr_o
);

    pwr_e state_d, state_q;
    cmd_e raw_cmd;

    always_comb begin
        raw_cmd = decode_pins(cs_n, ras_n, cas_n, we_n);
        state_d = state_q;
        case (state_q)
            PW_RUN: begin
                if (!cke) begin
                    if (raw_cmd == CMD_REF) state_d = PW_SREF;
                    else if (any_open)      state_d = PW_APD;
                    else                    state_d = PW_PPD;
                end
            end
            default: if (cke) state_d = PW_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PW_RUN;
        else        state_q <= state_d;
    end

    assign accept = (state_q == PW_RUN) && cke;
    // Self-refresh exit is seen straight from CKE, without a clock edge.
    assign pwr_o  = (state_q == PW_SREF && cke) ? PW_RUN : state_q;

    a_r9_apd_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PW_RUN && !cke && any_open && raw_cmd != CMD_REF) |=> (pwr_o == PW_APD));

    a_r10_pd_holds: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == PW_PPD || state_q == PW_APD) && !cke) |=> (state_q == $past(state_q)));

endmodule

// File: rtl/ddr2_fe_decode.sv
module ddr2_fe_decode
    import ddr2_fe_pkg::*;
#(
    parameter int BA_W   = 3,
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [BA_W-1:0]   ba_raw,
    input  logic [BA_W-1:0]   ba_eff,
    input  logic [ADDR_W-1:0] addr,
    output cmd_e              cmd_now,
    output logic [2:0]        cmd_o,
    output logic [BA_W-1:0]   bank_o,
    output logic [ADDR_W-2:0] col_o,
    output logic              a10_o,
    output logic [BA_W-1:0]   mode_sel_o,
    output logic [ADDR_W-1:0] mode_op_o
);

    localparam int COL_W = ADDR_W - 1;

    typedef struct packed {
        cmd_e              cmd;
        logic [BA_W-1:0]   bank;
        logic [COL_W-1:0]  col;
        logic              a10;
        logic [BA_W-1:0]   msel;
        logic [ADDR_W-1:0] mop;
    } dec_t;

    dec_t d, q;

    always_comb begin
        cmd_now = accept ? decode_pins(cs_n, ras_n, cas_n, we_n) : CMD_NOP;
        d      = '0;
        d.cmd  = cmd_now;
        d.bank = ba_eff;
        d.a10  = addr[10];
        if (cmd_now == CMD_RD || cmd_now == CMD_WR) begin
            for (int i = 0; i < COL_W; i++)
                d.col[i] = (i < 10) ? addr[i] : addr[i+1];
        end
        if (cmd_now == CMD_MRS) begin
            d.msel = ba_raw;
            d.mop  = addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cmd_o      = q.cmd;
    assign bank_o     = q.bank;
    assign col_o      = q.col;
    assign a10_o      = q.a10;
    assign mode_sel_o = q.msel;
    assign mode_op_o  = q.mop;

    a_r2_cs_masks: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (cmd_o == CMD_NOP));

    a_r7_mode_fields: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_now == CMD_MRS) |=> (mode_sel_o == $past(ba_raw) && mode_op_o == $past(addr)));

endmodule

// File: rtl/ddr2_fe_banks.sv
module ddr2_fe_banks
    import ddr2_fe_pkg::*;
#(
    parameter int TRACK_W = 3,
    parameter int ADDR_W  = 14
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  cmd_e                         cmd_now,
    input  logic [TRACK_W-1:0]           bank,
    input  logic [ADDR_W-1:0]            addr,
    output logic [(1<<TRACK_W)-1:0]      open_o,
    output logic [(1<<TRACK_W)*ADDR_W-1:0] row_o,
    output logic                         any_open,
    output logic                         err_o
);

    localparam int NB = 1 << TRACK_W;

    typedef struct packed {
        logic [NB-1:0]             open;
        logic [NB-1:0][ADDR_W-1:0] row;
        logic                      err;
    } bank_t;

    bank_t d, q;
    logic  hit;

    always_comb begin
        d     = q;
        d.err = 1'b0;
        hit   = q.open[bank];
        case (cmd_now)
            CMD_ACT: begin
                if (hit) d.err = 1'b1;
                else begin
                    d.open[bank] = 1'b1;
                    d.row[bank]  = addr;
                end
            end
            CMD_RD, CMD_WR: begin
                if (!hit)         d.err = 1'b1;
                else if (addr[10]) d.open[bank] = 1'b0;
            end
            CMD_PRE: begin
                if (addr[10])  d.open = '0;
                else if (!hit) d.err = 1'b1;
                else           d.open[bank] = 1'b0;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign open_o   = q.open;
    assign row_o    = q.row;
    assign any_open = |q.open;
    assign err_o    = q.err;

    a_r6_pre_all_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_now == CMD_PRE && addr[10]) |=> (open_o == '0));

    a_r8_act_open_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_now == CMD_ACT && open_o[bank]) |=> (err_o && $stable(row_o)));

    a_r5_autopre_closes: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd_now == CMD_RD || cmd_now == CMD_WR) && addr[10]) |=> !open_o[$past(bank)]);

endmodule

// File: rtl/ddr2_cmd_front.sv
module ddr2_cmd_front
    import ddr2_fe_pkg::*;
#(
    parameter int BA_W   = 3,
    parameter int ADDR_W = 14,
    parameter bit SMALL  = 1'b0
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cke,
    input  logic                          cs_n,
    input  logic                          ras_n,
    input  logic                          cas_n,
    input  logic                          we_n,
    input  logic [BA_W-1:0]               ba,
    input  logic [ADDR_W-1:0]             addr,
    output logic [2:0]                    cmd_o,
    output logic [BA_W-1:0]               bank_o,
    output logic [ADDR_W-2:0]             col_o,
    output logic                          a10_o,
    output logic [BA_W-1:0]               mode_sel_o,
    output logic [ADDR_W-1:0]             mode_op_o,
    output logic                          err_o,
    output logic [(1<<BA_W)-1:0]          bank_open_o,
    output logic [(1<<BA_W)*ADDR_W-1:0]   row_o,
    output logic [1:0]                    pwr_o
);

    localparam int TRACK_W = SMALL ? BA_W - 1 : BA_W;
    localparam int NB      = 1 << TRACK_W;
    localparam int NB_OUT  = 1 << BA_W;

    logic                  accept;
    logic                  any_open;
    cmd_e                  cmd_now;
    logic [TRACK_W-1:0]    bank_eff;
    logic [BA_W-1:0]       ba_eff;
    logic [NB-1:0]         open_t;
    logic [NB*ADDR_W-1:0]  row_t;

    assign bank_eff = ba[TRACK_W-1:0];
    assign ba_eff   = BA_W'(bank_eff);

    ddr2_fe_pwr u_pwr (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .any_open(any_open),
        .accept(accept), .pwr_o(pwr_o)
    );

    ddr2_fe_decode #(.BA_W(BA_W), .ADDR_W(ADDR_W)) u_dec (
        .clk(clk), .rst_n(rst_n), .accept(accept), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .ba_raw(ba), .ba_eff(ba_eff), .addr(addr),
        .cmd_now(cmd_now), .cmd_o(cmd_o), .bank_o(bank_o), .col_o(col_o),
        .a10_o(a10_o), .mode_sel_o(mode_sel_o), .mode_op_o(mode_op_o)
    );

    ddr2_fe_banks #(.TRACK_W(TRACK_W), .ADDR_W(ADDR_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .cmd_now(cmd_now), .bank(bank_eff), .addr(addr),
        .open_o(open_t), .row_o(row_t), .any_open(any_open), .err_o(err_o)
    );

    generate
        if (NB < NB_OUT) begin : g_pad
            assign bank_open_o = {{(NB_OUT-NB){1'b0}}, open_t};
            assign row_o       = {{((NB_OUT-NB)*ADDR_W){1'b0}}, row_t};
            a_r12_upper_closed: assert property (@(posedge clk) disable iff (!rst_n)
                bank_open_o[NB_OUT-1:NB] == '0);
        end else begin : g_full
            assign bank_open_o = open_t;
            assign row_o       = row_t;
        end
    endgenerate

    a_r10_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> ($stable(bank_open_o) && cmd_o == CMD_NOP));

endmodule

// File: tb/sim_ddr2_cmd_front.sv
module sim_ddr2_cmd_front;

    localparam int AW = 14;

    logic clk = 1'b0, rst_n = 1'b0, cke = 1'b1;
    logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [2:0] ba = '0;
    logic [AW-1:0] addr = '0;

    logic [2:0] cmd_o, bank_o, msel, cmd1, bank1, msel1;
    logic [AW-2:0] col_o, col1;
    logic a10_o, err_o, a101, err1;
    logic [AW-1:0] mop, mop1;
    logic [7:0] open_o, open1;
    logic [8*AW-1:0] row_o, row1;
    logic [1:0] pwr_o, pwr1;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    ddr2_cmd_front u0 (.clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .cmd_o(cmd_o), .bank_o(bank_o),
        .col_o(col_o), .a10_o(a10_o), .mode_sel_o(msel), .mode_op_o(mop), .err_o(err_o),
        .bank_open_o(open_o), .row_o(row_o), .pwr_o(pwr_o));

    ddr2_cmd_front #(.SMALL(1'b1)) u1 (.clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n),
        .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .cmd_o(cmd1),
        .bank_o(bank1), .col_o(col1), .a10_o(a101), .mode_sel_o(msel1), .mode_op_o(mop1),
        .err_o(err1), .bank_open_o(open1), .row_o(row1), .pwr_o(pwr1));

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic issue(input logic [2:0] rcw, input logic [2:0] b, input logic [AW-1:0] a);
        cs_n = 1'b0; {ras_n, cas_n, we_n} = rcw; ba = b; addr = a;
        step();
        cs_n = 1'b1; {ras_n, cas_n, we_n} = 3'b111;
    endtask

    function automatic logic [AW-2:0] col_of(input logic [AW-1:0] a);
        return {a[AW-1:11], a[9:0]};
    endfunction

    function automatic logic [AW-1:0] row_of(input int b);
        return AW'(b * 37 + 5);
    endfunction

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] exp_open;
        #12 rst_n = 1'b1;
        step();
        chk("R1 pwr", pwr_o, 0); chk("R1 open", open_o, 0);
        chk("R1 cmd", cmd_o, 0); chk("R1 err", err_o, 0); chk("R1 rows", row_o, 0);

        // R2: chip select high masks an ACTIVE code
        for (int b = 0; b < 8; b++) begin
            cs_n = 1'b1; {ras_n, cas_n, we_n} = 3'b011; ba = 3'(b); addr = row_of(b);
            step();
            chk("R2 cmd", cmd_o, 0); chk("R2 open", open_o, 0);
        end

        // R4 / R12: open every bank
        exp_open = 0;
        for (int b = 0; b < 8; b++) begin
            issue(3'b011, 3'(b), row_of(b));
            exp_open[b] = 1'b1;
            chk("R3 act code", cmd_o, 1); chk("R4 bank", bank_o, b);
            chk("R4 open", open_o, exp_open); chk("R4 row", row_o[b*AW +: AW], row_of(b));
            chk("R8 no err", err_o, 0);
            chk("R12 small err", err1, (b >= 4));
        end
        chk("R12 small open", open1, 8'h0F);
        chk("R12 small row kept", row1[1*AW +: AW], row_of(1));

        // R8: ACTIVE to open bank
        issue(3'b011, 3'd2, 14'h1234);
        chk("R8 act err", err_o, 1); chk("R8 row kept", row_o[2*AW +: AW], row_of(2));
        step();
        chk("R8 pulse", err_o, 0);

        // R4 / R5: accesses, odd banks with auto-precharge
        for (int b = 0; b < 8; b++) begin
            logic [AW-1:0] a;
            a = (b % 2) ? AW'(14'h0C00 | (b * 5)) : AW'(b * 3 + 100);
            issue((b % 2) ? 3'b100 : 3'b101, 3'(b), a);
            if (b % 2) exp_open[b] = 1'b0;
            chk("R3 rd/wr code", cmd_o, (b % 2) ? 3 : 2);
            chk("R4 col", col_o, col_of(a)); chk("R4 a10", a10_o, b % 2);
            chk("R5 open", open_o, exp_open); chk("R4 no err", err_o, 0);
        end
        chk("R5 final", open_o, 8'h55);

        issue(3'b101, 3'd1, 14'd7);
        chk("R8 rd idle", err_o, 1);

        // R6: single-bank precharge
        issue(3'b010, 3'd0, 14'd0);
        chk("R3 pre code", cmd_o, 4); chk("R6 single", open_o, 8'h54); chk("R6 err", err_o, 0);
        issue(3'b010, 3'd1, 14'd0);
        chk("R8 pre idle", err_o, 1); chk("R8 pre idle open", open_o, 8'h54);

        // R7: mode set sweep
        for (int b = 0; b < 8; b++) begin
            issue(3'b000, 3'(b), AW'(b * 291 + 3));
            chk("R7 code", cmd_o, 5); chk("R7 sel", msel, b); chk("R7 op", mop, AW'(b * 291 + 3));
        end
        issue(3'b001, 3'd0, 14'd0);
        chk("R3 ref code", cmd_o, 6); chk("R7 zero", mop, 0); chk("R3 ref open", open_o, 8'h54);
        issue(3'b110, 3'd0, 14'd0);
        chk("R3 other code", cmd_o, 0);

        // R6: precharge all
        issue(3'b010, 3'd5, 14'h0400);
        chk("R6 all", open_o, 0); chk("R6 all err", err_o, 0);

        // R9 / R10: active power-down
        issue(3'b011, 3'd3, 14'd9);
        cke = 1'b0; step();
        chk("R9 apd", pwr_o, 2);
        cke = 1'b0; issue(3'b011, 3'd4, 14'd1);
        chk("R10 ignored cmd", cmd_o, 0); chk("R10 ignored open", open_o, 8'h08); chk("R10 stay", pwr_o, 2);
        cke = 1'b1; issue(3'b011, 3'd5, 14'd1);
        chk("R10 exit", pwr_o, 0); chk("R10 exit edge open", open_o, 8'h08); chk("R10 exit cmd", cmd_o, 0);

        // R9: precharge power-down
        issue(3'b010, 3'd0, 14'h0400);
        cke = 1'b0; step();
        chk("R9 ppd", pwr_o, 1);
        cke = 1'b1; step();
        chk("R10 ppd exit", pwr_o, 0);

        // R9 / R10: command and CKE fall on the same edge, all banks idle
        cke = 1'b0; issue(3'b011, 3'd6, 14'd3);
        chk("R9 ppd with act", pwr_o, 1); chk("R10 entry edge open", open_o, 0);
        cke = 1'b1; step();
        chk("R10 back", pwr_o, 0);

        // R9 / R11: self refresh
        cke = 1'b0; issue(3'b001, 3'd0, 14'd0);
        chk("R9 sref", pwr_o, 3);
        step(); step();
        chk("R9 sref hold", pwr_o, 3);
        cke = 1'b1; #1;
        chk("R11 async exit", pwr_o, 0);
        step();
        chk("R11 run", pwr_o, 0); chk("R11 cmd", cmd_o, 0);
        issue(3'b011, 3'd7, 14'd2);
        chk("R11 usable", open_o, 8'h80);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule